// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan timing for a raster display: a pixel counter and a line counter, horizontal and vertical sync pulses, a data-enable strobe, zero-based pixel coordinates, a field indicator and a one-cycle frame-start pulse. All geometry comes in on configuration inputs. These are active width and height, front porch, sync width and a "lead" span for each axis. The lead span runs from the first cycle of sync to the first active pixel or line, so it already contains the sync width. The horizontal line period is therefore active plus front porch plus lead.

Scanning is progressive or interlaced. In interlaced mode each field carries half of the active height and its own front porch and lead. Each sync has its own active-low select, and a force input overrides both selects so that both syncs are active-high. A static channel-select input chooses the secondary variant. On that variant in progressive mode, the vertical counter runs in half-line units, and the visible timing stays the same. The block also reports a start-of-frame clock-delay value, saturated at 30, which a downstream pipeline uses for alignment. Configuration is sampled once after reset and then only at frame boundaries, so no frame mixes two timings.

Top module: `disp_timing_gen`

## Requirements
- R1: One line lasts h_active + h_front + h_lead cycles. Horizontal count 0 is the first cycle of hsync, and the first active pixel is at count h_lead.
- R2: In progressive mode a frame lasts (v_active + v_front + v_lead) lines. Line 0 is the first line of vsync, and the first active line is line v_lead.
- R3: de is high only when both counters are inside their active windows. While de is high, pix_x and pix_y give the zero-based position in that window (pix_y counts lines within the field). Both are 0 while de is low. The first de of a frame comes v_lead*line_period + h_lead cycles after frame_start.
- R4: hsync is active during the first h_sync cycles of every line. vsync is active for all cycles of the first v_sync lines of every field.
- R5: Each sync is active-high by default and active-low when its low-select input is 1. When cfg_force_high is 1, both syncs are active-high whatever the low-select inputs are.
- R6: clk_delay = v_front + v_lead, halved (rounding down) in interlaced mode, then reduced by 2 on the secondary channel with a floor at 0, then capped at 30.
- R7: On the secondary channel in progressive mode, the vertical counter steps by two half-lines per line and holds an even value. Output timing is identical to the primary channel.
- R8: In interlaced mode each field has v_active/2 active lines plus v_front + v_lead blanking lines, so a frame spans two such fields.
- R9: New configuration takes effect only at the first cycle of a frame (count 0, line 0, field 0). A change in mid-frame leaves the rest of that frame unchanged.
- R10: field is 1 during the second field of an interlaced frame and changes only on the first cycle of a field. In progressive mode it stays 0.
- R11: frame_start is high for exactly the first cycle of each frame, and only while field is 0.
- R12: During reset de, frame_start, field, hsync, vsync, pix_x and pix_y are 0. The first frame_start appears in the cycle after the first clock edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_h_active | input | 12 | Active pixels per line |
| cfg_h_front | input | 12 | Horizontal front porch |
| cfg_h_sync | input | 12 | hsync width |
| cfg_h_lead | input | 12 | Cycles from hsync start to first active pixel (sync + back porch) |
| cfg_v_active | input | 12 | Active lines per frame |
| cfg_v_front | input | 12 | Vertical front porch, lines |
| cfg_v_sync | input | 12 | vsync width, lines |
| cfg_v_lead | input | 12 | Lines from vsync start to first active line (sync + back porch) |
| cfg_interlace | input | 1 | 1 = interlaced, 0 = progressive |
| cfg_hs_low | input | 1 | hsync active-low select |
| cfg_vs_low | input | 1 | vsync active-low select |
| cfg_force_high | input | 1 | Force both syncs active-high |
| sec_chan | input | 1 | Secondary channel variant select (static) |
| pix_x | output | 12 | Active pixel column |
| pix_y | output | 12 | Active line within the field |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| de | output | 1 | Data enable |
| field | output | 1 | Current field of an interlaced frame |
| frame_start | output | 1 | One-cycle pulse at the start of each frame |
| clk_delay | output | 5 | Saturated start-of-frame clock delay |

## Verification
The assertions check the following on every cycle: frame_start is never raised in field 1; field and the applied configuration change only on the cycle at count 0, line 0; the half-line vertical count stays even; clk_delay never exceeds 30; and de never overlaps an active hsync or runs past the active width. Some properties only the bench scenarios can show, because they depend on counting across a whole frame: the line and frame periods, the number of de, sync and field-1 cycles per frame, the offset of the first pixel, the delay arithmetic including its floor and cap, and the fact that a mid-frame reprogramming leaves that frame's length unchanged.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int CW        = 12;      // configuration / coordinate width
  localparam int TW        = CW + 2;  // line and period sums
  localparam int VW        = CW + 3;  // vertical count in half-line units
  localparam int DLY_W     = 5;
  localparam int DLY_MAX   = 30;
  localparam int CH2_TRIM  = 2;       // delay reduction on the secondary channel

  typedef struct packed {
    logic [CW-1:0] h_act;
    logic [CW-1:0] h_fp;
    logic [CW-1:0] h_sw;
    logic [CW-1:0] h_lead;
    logic [CW-1:0] v_act;
    logic [CW-1:0] v_fp;
    logic [CW-1:0] v_sw;
    logic [CW-1:0] v_lead;
    logic          interlace;
    logic          hs_low;
    logic          vs_low;
    logic          force_hi;
    logic          secondary;
  } dtg_cfg_t;

  // active lines carried by one field
  function automatic logic [CW-1:0] field_lines(input dtg_cfg_t c);
    return c.interlace ? (c.v_act >> 1) : c.v_act;
  endfunction
endpackage

// File: rtl/dtg_shadow.sv
module dtg_shadow
  import dtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  dtg_cfg_t         cfg_in,
  input  logic             frame_end,
  output dtg_cfg_t         cfg_q,
  output logic             run_q,
  output logic [DLY_W-1:0] clk_delay
);
  logic     load_en;
  logic     run_d;
  dtg_cfg_t cfg_d;
  logic [CW:0] blank, halved, trimmed;

  // capture once after reset, then only on the frame boundary
  always_comb begin
    load_en = !run_q || frame_end;
    cfg_d   = load_en ? cfg_in : cfg_q;
    run_d   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      run_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      run_q <= run_d;
    end
  end

  // vertical blanking -> alignment delay
  always_comb begin
    blank  = {1'b0, cfg_q.v_fp} + {1'b0, cfg_q.v_lead};
    halved = cfg_q.interlace ? (blank >> 1) : blank;
    if (cfg_q.secondary)
      trimmed = (halved >= (CW+1)'(CH2_TRIM)) ? halved - (CW+1)'(CH2_TRIM) : '0;
    else
      trimmed = halved;
    clk_delay = (trimmed > (CW+1)'(DLY_MAX)) ? DLY_W'(DLY_MAX) : trimmed[DLY_W-1:0];
  end
endmodule

// File: rtl/dtg_counters.sv
module dtg_counters
  import dtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  dtg_cfg_t      cfg,
  output logic [TW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic [TW-1:0] line,
  output logic          field,
  output logic          half_mode,
  output logic          frame_end
);
  logic [TW-1:0] htot, vlines, h_d;
  logic [VW-1:0] vlast, vstep, v_d;
  logic          line_end, field_end, f_d;

  always_comb begin
    htot      = TW'(cfg.h_act) + TW'(cfg.h_fp) + TW'(cfg.h_lead);
    vlines    = TW'(field_lines(cfg)) + TW'(cfg.v_fp) + TW'(cfg.v_lead);
    half_mode = cfg.secondary && !cfg.interlace;
    vstep     = half_mode ? VW'(2) : VW'(1);
    vlast     = half_mode ? ((VW'(vlines) << 1) - VW'(2)) : (VW'(vlines) - VW'(1));
    line_end  = (h_cnt == htot - TW'(1));
    field_end = line_end && (v_cnt == vlast);
    frame_end = run && field_end && (!cfg.interlace || field);
    line      = half_mode ? TW'(v_cnt >> 1) : TW'(v_cnt);
  end

  always_comb begin
    h_d = h_cnt;
    v_d = v_cnt;
    f_d = field;
    if (run) begin
      if (line_end) begin
        h_d = '0;
        if (field_end) begin
          v_d = '0;
          f_d = cfg.interlace && !field;
        end else begin
          v_d = v_cnt + vstep;
        end
      end else begin
        h_d = h_cnt + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
      field <= 1'b0;
    end else begin
      h_cnt <= h_d;
      v_cnt <= v_d;
      field <= f_d;
    end
  end
endmodule

// File: rtl/dtg_decode.sv
module dtg_decode
  import dtg_pkg::*;
(
  input  logic          run,
  input  logic [TW-1:0] h_cnt,
  input  logic [TW-1:0] line,
  input  logic          field,
  input  dtg_cfg_t      cfg,
  output logic          de,
  output logic          hsync,
  output logic          vsync,
  output logic          frame_start,
  output logic          hs_inv,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y
);
  logic          h_in, v_in, hs_raw, vs_raw, vs_inv;
  logic [TW-1:0] hx, vy;

  always_comb begin
    hx     = h_cnt - TW'(cfg.h_lead);
    vy     = line - TW'(cfg.v_lead);
    h_in   = (h_cnt >= TW'(cfg.h_lead)) && (hx < TW'(cfg.h_act));
    v_in   = (line >= TW'(cfg.v_lead)) && (vy < TW'(field_lines(cfg)));
    de     = run && h_in && v_in;
    pix_x  = de ? hx[CW-1:0] : '0;
    pix_y  = de ? vy[CW-1:0] : '0;
    hs_raw = run && (h_cnt < TW'(cfg.h_sw));
    vs_raw = run && (line < TW'(cfg.v_sw));
    hs_inv = cfg.hs_low && !cfg.force_hi;
    vs_inv = cfg.vs_low && !cfg.force_hi;
    hsync  = hs_raw ^ hs_inv;
    vsync  = vs_raw ^ vs_inv;
    frame_start = run && (h_cnt == '0) && (line == '0) && !field;
  end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cfg_h_active,
  input  logic [CW-1:0]    cfg_h_front,
  input  logic [CW-1:0]    cfg_h_sync,
  input  logic [CW-1:0]    cfg_h_lead,
  input  logic [CW-1:0]    cfg_v_active,
  input  logic [CW-1:0]    cfg_v_front,
  input  logic [CW-1:0]    cfg_v_sync,
  input  logic [CW-1:0]    cfg_v_lead,
  input  logic             cfg_interlace,
  input  logic             cfg_hs_low,
  input  logic             cfg_vs_low,
  input  logic             cfg_force_high,
  input  logic             sec_chan,
  output logic [CW-1:0]    pix_x,
  output logic [CW-1:0]    pix_y,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             field,
  output logic             frame_start,
  output logic [DLY_W-1:0] clk_delay
);
  dtg_cfg_t      cfg_in, cfg_q;
  logic          run_q, frame_end, half_mode, hs_inv;
  logic [TW-1:0] h_cnt, line;
  logic [VW-1:0] v_cnt;

  always_comb begin
    cfg_in.h_act     = cfg_h_active;
    cfg_in.h_fp      = cfg_h_front;
    cfg_in.h_sw      = cfg_h_sync;
    cfg_in.h_lead    = cfg_h_lead;
    cfg_in.v_act     = cfg_v_active;
    cfg_in.v_fp      = cfg_v_front;
    cfg_in.v_sw      = cfg_v_sync;
    cfg_in.v_lead    = cfg_v_lead;
    cfg_in.interlace = cfg_interlace;
    cfg_in.hs_low    = cfg_hs_low;
    cfg_in.vs_low    = cfg_vs_low;
    cfg_in.force_hi  = cfg_force_high;
    cfg_in.secondary = sec_chan;
  end

  dtg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .frame_end(frame_end),
    .cfg_q(cfg_q), .run_q(run_q), .clk_delay(clk_delay)
  );

  dtg_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .cfg(cfg_q),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .line(line), .field(field),
    .half_mode(half_mode), .frame_end(frame_end)
  );

  dtg_decode u_dec (
    .run(run_q), .h_cnt(h_cnt), .line(line), .field(field), .cfg(cfg_q),
    .de(de), .hsync(hsync), .vsync(vsync), .frame_start(frame_start),
    .hs_inv(hs_inv), .pix_x(pix_x), .pix_y(pix_y)
  );
endmodule

// File: rtl/dtg_chk.sv
module dtg_chk
  import dtg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             field,
  input logic             de,
  input logic             hsync,
  input logic             hs_inv,
  input logic [CW-1:0]    pix_x,
  input logic [DLY_W-1:0] clk_delay,
  input dtg_cfg_t         cfg_q,
  input logic [TW-1:0]    h_cnt,
  input logic [VW-1:0]    v_cnt,
  input logic             half_mode
);
  // R11
  fs_field0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !field);

  // R10
  field_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field) |-> (h_cnt == '0 && v_cnt == '0));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> (h_cnt == '0 && v_cnt == '0 && !field));

  // R7
  half_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_mode |-> !v_cnt[0]);

  // R6
  dly_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_delay <= DLY_W'(DLY_MAX));

  // R4
  de_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync == hs_inv));

  // R3
  de_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (pix_x < cfg_q.h_act));
endmodule

bind disp_timing_gen dtg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .field(field),
  .de(de), .hsync(hsync), .hs_inv(hs_inv), .pix_x(pix_x),
  .clk_delay(clk_delay), .cfg_q(cfg_q), .h_cnt(h_cnt), .v_cnt(v_cnt),
  .half_mode(half_mode)
);

// File: tb/tb_disp_timing_gen.sv
`timescale 1ns/1ps
module tb_disp_timing_gen;
  logic        clk, rst_n;
  logic [11:0] h_act, h_fp, h_sw, h_ld, v_act, v_fp, v_sw, v_ld;
  logic        il, hl, vl, frc, sec;
  logic [11:0] pix_x, pix_y;
  logic        hsync, vsync, de, field, frame_start;
  logic [4:0]  clk_delay;

  int checks = 0;
  int fails  = 0;

  disp_timing_gen dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_h_active(h_act), .cfg_h_front(h_fp), .cfg_h_sync(h_sw), .cfg_h_lead(h_ld),
    .cfg_v_active(v_act), .cfg_v_front(v_fp), .cfg_v_sync(v_sw), .cfg_v_lead(v_ld),
    .cfg_interlace(il), .cfg_hs_low(hl), .cfg_vs_low(vl), .cfg_force_high(frc),
    .sec_chan(sec), .pix_x(pix_x), .pix_y(pix_y), .hsync(hsync), .vsync(vsync),
    .de(de), .field(field), .frame_start(frame_start), .clk_delay(clk_delay)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ha hf hs hl | va vf vs vl | il hlow vlow force sec | cyc de hs vs f1 dly firstde
  localparam int NV = 6;
  localparam int TBL [NV][20] = '{
    '{4,2,2,3, 4,1,1,2,  0,0,0,0,0,  63,16,14, 9,  0, 3,21},
    '{4,2,2,3, 4,1,1,2,  0,1,1,0,1,  63,16,14, 9,  0, 1,21},
    '{4,2,2,3, 4,1,1,2,  1,0,0,0,0,  90,16,20,18, 45, 1,21},
    '{4,2,2,3, 4,10,1,3, 1,0,0,0,1, 270,16,60,18,135, 4,30},
    '{4,2,2,3, 2,40,1,5, 0,1,1,1,0, 423, 8,94, 9,  0,30,48},
    '{4,2,2,3, 2,0,1,1,  0,0,1,0,1,  27, 8, 6, 9,  0, 0,12}
  };

  int m_cyc, m_de, m_hs, m_vs, m_f1, m_first, m_lx, m_ly, m_dly;

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic set_cfg(input int r);
    h_act = 12'(TBL[r][0]);  h_fp = 12'(TBL[r][1]);
    h_sw  = 12'(TBL[r][2]);  h_ld = 12'(TBL[r][3]);
    v_act = 12'(TBL[r][4]);  v_fp = 12'(TBL[r][5]);
    v_sw  = 12'(TBL[r][6]);  v_ld = 12'(TBL[r][7]);
    il  = TBL[r][8] != 0;  hl  = TBL[r][9] != 0;  vl = TBL[r][10] != 0;
    frc = TBL[r][11] != 0; sec = TBL[r][12] != 0;
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start);
  endtask

  // called at a negedge where frame_start is high; stops at the next one
  task automatic measure(input logic hlvl, input logic vlvl);
    m_cyc = 0; m_de = 0; m_hs = 0; m_vs = 0; m_f1 = 0;
    m_first = -1; m_lx = -1; m_ly = -1;
    m_dly = int'(clk_delay);
    do begin
      if (de) begin
        if (m_first < 0) m_first = m_cyc;
        m_de++;
        m_lx = int'(pix_x);
        m_ly = int'(pix_y);
      end
      if (hsync == hlvl) m_hs++;
      if (vsync == vlvl) m_vs++;
      if (field) m_f1++;
      m_cyc++;
      @(negedge clk);
    end while (!frame_start);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    set_cfg(0);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 de in reset", int'(de), 0);
    chk("R12 frame_start in reset", int'(frame_start), 0);
    chk("R12 field in reset", int'(field), 0);
    chk("R12 hsync in reset", int'(hsync), 0);
    chk("R12 vsync in reset", int'(vsync), 0);
    chk("R12 pix in reset", int'(pix_x) + int'(pix_y), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 R11 first frame_start", int'(frame_start), 1);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R10 R11
    for (int r = 0; r < NV; r++) begin
      logic hlvl, vlvl;
      int lines;
      set_cfg(r);
      hlvl  = !(hl && !frc);
      vlvl  = !(vl && !frc);
      lines = il ? TBL[r][4] / 2 : TBL[r][4];
      wait_fs();
      measure(hlvl, vlvl);
      chk($sformatf("R1 R2 R8 R11 frame cycles v%0d", r), m_cyc, TBL[r][13]);
      chk($sformatf("R3 de count v%0d", r), m_de, TBL[r][14]);
      chk($sformatf("R4 R5 hsync active v%0d", r), m_hs, TBL[r][15]);
      chk($sformatf("R4 R5 vsync active v%0d", r), m_vs, TBL[r][16]);
      chk($sformatf("R10 field1 cycles v%0d", r), m_f1, TBL[r][17]);
      chk($sformatf("R6 clk_delay v%0d", r), m_dly, TBL[r][18]);
      chk($sformatf("R3 first de offset v%0d", r), m_first, TBL[r][19]);
      chk($sformatf("R3 last pix_x v%0d", r), m_lx, TBL[r][0] - 1);
      chk($sformatf("R3 R7 R8 last pix_y v%0d", r), m_ly, lines - 1);
    end

    // R9: change the configuration in the middle of a frame
    begin
      int n;
      set_cfg(0);
      wait_fs();
      measure(1'b1, 1'b1);
      repeat (10) @(negedge clk);
      set_cfg(2);
      n = 10;
      do begin @(negedge clk); n++; end while (!frame_start);
      chk("R9 frame unchanged after mid-frame write", n, 63);
      measure(1'b1, 1'b1);
      chk("R9 new timing from next frame", m_cyc, 90);
    end

    // R3: outside de the coordinates read 0
    begin
      int bad = 0;
      set_cfg(0);
      wait_fs();
      for (int i = 0; i < 63; i++) begin
        if (!de && (pix_x != 0 || pix_y != 0)) bad++;
        @(negedge clk);
      end
      chk("R3 coordinates zero outside de", bad, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule